// File: doc/BRIEF.md
# Instruction Location Counter with Interrupt Control Flags

This block keeps the address of the next macro-instruction as a 32-bit counter word and holds a 4-bit interrupt-control field beside it. Both are written over one shared write port. A destination code on that port selects the target, so the sequencer can load either value in a single cycle.

A write to the counter loads a new address. When the half-word addressing mode is selected, the address is forced to an even value. The write also raises a need-fetch flag, which the fetch unit clears with `fetch_done` once it has fetched from the new address.

A write to the control field loads four flags: sequence-break request, interrupt enable, bus reset and byte mode. These flags are also copied into the counter word, so any reader of the word sees them. The bus-reset flag additionally produces a one-cycle pulse for the rest of the system.

Top module: `fetch_locator`

## Requirements
- R1: A write with destination code 1 loads bits 25..1 of the counter word from `wr_data[25:1]` and leaves bits 30..26 unchanged.
- R2: When byte mode is clear, a counter write forces counter bit 0 to 0.
- R3: When byte mode is set, a counter write loads counter bit 0 from `wr_data[0]`.
- R4: Every counter write sets counter bit 31. That bit is the `need_fetch` output.
- R5: A write with destination code 2 loads the control flags from `wr_data[29:26]`:
  - bit 26 drives `sb_req`
  - bit 27 drives `int_en`
  - bit 29 drives `byte_mode`
- R6: A control write copies `wr_data[29:26]` into counter bits 29..26 and leaves every other counter bit unchanged.
- R7: `fetch_done` clears `need_fetch` one cycle later. If a counter write happens in the same cycle, the write wins and `need_fetch` stays set.
- R8: A control write with `wr_data[28]` = 1 makes `bus_reset` high for exactly the next cycle. A control write with that bit at 0 produces no pulse.
- R9: Writes with any other destination code, and cycles with `wr_en` low, change no output.
- R10: After reset, the counter word, `need_fetch`, all flags and `bus_reset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_dest | input | 5 | Destination code (1 = counter, 2 = control) |
| wr_data | input | 32 | Write data |
| fetch_done | input | 1 | Fetch unit has consumed the new address |
| lc_word | output | 32 | Full counter word: address, mirrored flags, need-fetch |
| need_fetch | output | 1 | Counter bit 31 |
| sb_req | output | 1 | Sequence-break request flag |
| int_en | output | 1 | Interrupt enable flag |
| byte_mode | output | 1 | Byte-addressing mode flag |
| bus_reset | output | 1 | One-cycle bus reset pulse |

## Verification
The hardest case to reach is a counter write and `fetch_done` in the same cycle, because in normal use `fetch_done` follows the write. The bench drives both on the same falling edge and checks that `need_fetch` remains set.

The choice of address alignment depends on the mode left by an earlier control write. For that reason, odd addresses are written once in byte mode and once again after half-word mode has been restored.

// File: rtl/fl_pkg.sv
package fl_pkg;
    localparam int WORD_W  = 32;
    localparam int NF_BIT  = 31;
    localparam int CTL_LSB = 26;
    localparam int CTL_W   = 4;
    localparam int SB_IDX  = 0;
    localparam int IE_IDX  = 1;
    localparam int BR_IDX  = 2;
    localparam int BM_IDX  = 3;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CTL_W-1:0]  ctl;
        logic              brst;
    } fl_state_t;
endpackage

// File: rtl/lc_align.sv
module lc_align #(
    parameter int ADDR_W = 26
) (
    input  logic [fl_pkg::WORD_W-1:0] cur_word,
    input  logic [ADDR_W-1:0]         new_addr,
    input  logic                      byte_mode,
    output logic [fl_pkg::WORD_W-1:0] next_word
);
    import fl_pkg::*;
    localparam int HI_W = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] aligned;

    always_comb begin
        aligned = new_addr;
        if (!byte_mode) begin
            aligned[0] = 1'b0;
        end
        next_word = {cur_word[WORD_W-1 -: HI_W], aligned};
        next_word[NF_BIT] = 1'b1;
    end
endmodule

// File: rtl/ctl_mirror.sv
module ctl_mirror (
    input  logic [fl_pkg::WORD_W-1:0] cur_word,
    input  logic [fl_pkg::CTL_W-1:0]  ctl,
    output logic [fl_pkg::WORD_W-1:0] next_word
);
    import fl_pkg::*;

    always_comb begin
        next_word = cur_word;
        next_word[CTL_LSB +: CTL_W] = ctl;
    end
endmodule

// File: rtl/fetch_locator.sv
module fetch_locator #(
    parameter int                ADDR_W  = 26,
    parameter int                DEST_W  = 5,
    parameter logic [DEST_W-1:0] DEST_LC = 5'd1,
    parameter logic [DEST_W-1:0] DEST_IC = 5'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [4:0]  wr_dest,
    input  logic [31:0] wr_data,
    input  logic        fetch_done,
    output logic [31:0] lc_word,
    output logic        need_fetch,
    output logic        sb_req,
    output logic        int_en,
    output logic        byte_mode,
    output logic        bus_reset
);
    import fl_pkg::*;

    fl_state_t st_d, st_q;
    logic [WORD_W-1:0] lc_wr_word;
    logic [WORD_W-1:0] ic_wr_word;
    logic [CTL_W-1:0]  ctl_in;
    logic              hit_lc;
    logic              hit_ic;
    logic              unused_hi;

    assign unused_hi = ^wr_data[WORD_W-1:CTL_LSB+CTL_W];
    assign ctl_in    = wr_data[CTL_LSB +: CTL_W];
    assign hit_lc    = wr_en && (wr_dest == DEST_LC);
    assign hit_ic    = wr_en && (wr_dest == DEST_IC);

    lc_align #(.ADDR_W(ADDR_W)) u_align (
        .cur_word (st_q.word),
        .new_addr (wr_data[ADDR_W-1:0]),
        .byte_mode(st_q.ctl[BM_IDX]),
        .next_word(lc_wr_word)
    );

    ctl_mirror u_mirror (
        .cur_word (st_q.word),
        .ctl      (ctl_in),
        .next_word(ic_wr_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.brst = 1'b0;
        if (fetch_done) begin
            st_d.word[NF_BIT] = 1'b0;
        end
        if (hit_lc) begin
            st_d.word = lc_wr_word;
        end else if (hit_ic) begin
            st_d.word         = ic_wr_word;
            st_d.word[NF_BIT] = fetch_done ? 1'b0 : st_q.word[NF_BIT];
            st_d.ctl          = ctl_in;
            st_d.brst         = ctl_in[BR_IDX];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lc_word    = st_q.word;
    assign need_fetch = st_q.word[NF_BIT];
    assign sb_req     = st_q.ctl[SB_IDX];
    assign int_en     = st_q.ctl[IE_IDX];
    assign byte_mode  = st_q.ctl[BM_IDX];
    assign bus_reset  = st_q.brst;
endmodule

// File: rtl/fetch_locator_chk.sv
module fetch_locator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [4:0]  wr_dest,
    input logic [31:0] wr_data,
    input logic        fetch_done,
    input logic [31:0] lc_word,
    input logic        need_fetch,
    input logic        byte_mode,
    input logic        bus_reset
);
    logic lc_w, ic_w;
    assign lc_w = wr_en && (wr_dest == 5'd1);
    assign ic_w = wr_en && (wr_dest == 5'd2);

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lc_w |=> lc_word[25:1] == $past(wr_data[25:1])); // R1
    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_w && !byte_mode) |=> !lc_word[0]); // R2
    AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_w && byte_mode) |=> lc_word[0] == $past(wr_data[0])); // R3
    AST_NF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        lc_w |=> need_fetch); // R4
    AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        ic_w |=> lc_word[29:26] == $past(wr_data[29:26])); // R6
    AST_NF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && !lc_w) |=> !need_fetch); // R7
    AST_BRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> $past(ic_w && wr_data[28])); // R8
    AST_BRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !ic_w) |=> !bus_reset); // R8
endmodule

bind fetch_locator fetch_locator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dest(wr_dest),
    .wr_data(wr_data), .fetch_done(fetch_done), .lc_word(lc_word),
    .need_fetch(need_fetch), .byte_mode(byte_mode), .bus_reset(bus_reset)
);

// File: tb/fetch_locator_bench.sv
`timescale 1ns/1ps
module fetch_locator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_dest = '0;
    logic [31:0] wr_data = '0;
    logic        fetch_done = 1'b0;
    logic [31:0] lc_word;
    logic        need_fetch, sb_req, int_en, byte_mode, bus_reset;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_lc = '0;
    logic [3:0]  exp_ctl = '0;

    always #4 clk = ~clk;

    fetch_locator u_fetch_locator (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dest(wr_dest),
        .wr_data(wr_data), .fetch_done(fetch_done), .lc_word(lc_word),
        .need_fetch(need_fetch), .sb_req(sb_req), .int_en(int_en),
        .byte_mode(byte_mode), .bus_reset(bus_reset)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " word"}, lc_word, exp_lc);
        check({req, " need_fetch"}, 32'(need_fetch), 32'(exp_lc[31]));
        check({req, " flags"}, {29'd0, byte_mode, int_en, sb_req},
              {29'd0, exp_ctl[3], exp_ctl[1], exp_ctl[0]});
    endtask

    // one write cycle; outputs sampled on the following falling edge
    task automatic do_write(logic [4:0] dest, logic [31:0] data, logic fd);
        @(negedge clk);
        wr_en = 1'b1; wr_dest = dest; wr_data = data; fetch_done = fd;
        @(negedge clk);
        wr_en = 1'b0; fetch_done = 1'b0;
    endtask

    task automatic model_lc(logic [31:0] data);
        exp_lc[25:0] = data[25:0];
        if (!exp_ctl[3]) exp_lc[0] = 1'b0;
        exp_lc[31] = 1'b1;
    endtask

    task automatic model_ic(logic [31:0] data);
        exp_ctl = data[29:26];
        exp_lc[29:26] = data[29:26];
    endtask

    task automatic t_reset();
        check("R10 bus_reset", 32'(bus_reset), 32'd0);
        check_all("R10");
    endtask

    task automatic t_half_write();
        do_write(5'd1, 32'hFFAB_CDEF, 1'b0);
        model_lc(32'hFFAB_CDEF);
        check_all("R1 R2 R4");
        check("R2 bit0", 32'(lc_word[0]), 32'd0);
    endtask

    task automatic t_fetch_clear();
        do_write(5'd7, 32'h0, 1'b1);
        exp_lc[31] = 1'b0;
        check_all("R7 clear");
    endtask

    task automatic t_ctl_write();
        do_write(5'd2, 32'h3800_0000, 1'b0);
        model_ic(32'h3800_0000);
        check_all("R5 R6");
        check("R8 pulse", 32'(bus_reset), 32'd1);
        @(negedge clk);
        check("R8 pulse end", 32'(bus_reset), 32'd0);
    endtask

    task automatic t_byte_write();
        do_write(5'd1, 32'h0123_4567, 1'b0);
        model_lc(32'h0123_4567);
        check_all("R3");
        check("R3 bit0", 32'(lc_word[0]), 32'd1);
    endtask

    task automatic t_race();
        do_write(5'd7, 32'h0, 1'b1);
        exp_lc[31] = 1'b0;
        do_write(5'd1, 32'h0000_0101, 1'b1);
        model_lc(32'h0000_0101);
        check_all("R7 write wins");
    endtask

    task automatic t_ignored();
        do_write(5'd0, 32'hFFFF_FFFF, 1'b0);
        check_all("R9 dest0");
        do_write(5'd3, 32'hFFFF_FFFF, 1'b0);
        check_all("R9 dest3");
        @(negedge clk);
        wr_en = 1'b0; wr_dest = 5'd1; wr_data = 32'h0000_0AAA;
        @(negedge clk);
        check_all("R9 wr_en low");
    endtask

    task automatic t_half_again();
        do_write(5'd2, 32'h0400_0000, 1'b1);
        model_ic(32'h0400_0000);
        exp_lc[31] = 1'b0;
        check_all("R6 R7 ctl");
        check("R8 no pulse", 32'(bus_reset), 32'd0);
        do_write(5'd1, 32'h0000_0033, 1'b0);
        model_lc(32'h0000_0033);
        check_all("R2 again");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_half_write();
        t_fetch_clear();
        t_ctl_write();
        t_byte_write();
        t_race();
        t_ignored();
        t_half_again();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule